// File: doc/BRIEF.md
# Serial Transmit Start and Frame-Sync Controller

This block decides the moment at which a synchronous serial transmitter begins sending its next word. It also makes a periodic frame-sync pulse from the transmit bit clock. All timing runs on the system clock. A one-cycle `bitTick` enable marks each transmit clock period. Every input condition is sampled only on a tick, and every count is a count of ticks.

A 32-bit configuration word is stored when `cfgWrite` is high. It selects one of eight start conditions and a start delay in ticks, which applies to every start condition. It also sets the frame-sync period. The start conditions are:
- a word waiting in the holding register, with back-to-back restart at the end of each transfer;
- the receiver's start event;
- a level on the external frame-sync line;
- an edge on the external frame-sync line.

The frame-sync line passes through a two-flop synchronizer before it is decoded. Once a start has been issued, the block ignores further start conditions until the transmitter reports the end of its transfer.

Top module: `ser_tx_start_ctrl`

## Requirements
- R1: During and after reset, the stored configuration is all zeros, so the mode is 0, there is no delay and there is no periodic frame sync. `txStart` and `fsyncOut` are low while `rstN` is low.
- R2: In mode 0, when idle, a tick with `txEnable` and `wordReady` high makes `txStart` pulse for one cycle in the next cycle. A tick on which `xferDone` is high while `wordReady` is still high starts the next transfer in the same way, without returning to idle.
- R3: In mode 1, a tick with `rxStart` high starts transmission, and `wordReady` has no effect on starting.
- R4: Modes 2 (line low) and 3 (line high) are level triggered on the synchronized line. `txStart` pulses 3 ticks after the tick on which `fsyncIn` changes. If the level still holds on the tick that completes a transfer, the next transfer starts.
- R5: Mode 4 starts on a falling edge of the synchronized line, and mode 5 on a rising edge. Modes 6 and 7 start on any change of the line. An edge causes at most one start, and `txStart` pulses 3 ticks after `fsyncIn` changes.
- R6: Mode values 8 to 15 never start a transmission.
- R7: With a nonzero delay D, `txStart` pulses exactly D ticks later than it would with D = 0. This holds in every mode, including mode 1 and the completion-tick restart of R2.
- R8: Start conditions that occur while a delay countdown or a transfer is in progress are ignored. The exception is the completion tick of R2 and R4.
- R9: While `txEnable` is low, no start is issued. Dropping `txEnable` during a delay countdown cancels that start.
- R10: With a period field of 0, `fsyncOut` stays low.
- R11: With a period field P > 0 and `txEnable` high, `fsyncOut` pulses for one cycle once every 2*(P+1) ticks.
  - Clearing: a configuration write or a low `txEnable` clears the period count.
  - First pulse after a write: 2*(P+1)+1 cycles after the cycle in which `cfgWrite` was high, with a tick every cycle.
  - First pulse after enabling: 2*(P+1) cycles after `txEnable` rises.
- R12: In the configuration word, bits 31:24 hold the period field P, bits 23:16 hold the delay D, and bits 11:8 hold the mode. The other bits are ignored. The word takes effect in the cycle after `cfgWrite`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle enable marking each transmit clock period |
| txEnable | input | 1 | Transmitter enabled |
| wordReady | input | 1 | A word is waiting in the holding register |
| xferDone | input | 1 | The transfer in progress ends on this tick |
| rxStart | input | 1 | Receiver start event |
| fsyncIn | input | 1 | External frame-sync line, asynchronous |
| cfgWrite | input | 1 | Store `cfgWord` as the configuration |
| cfgWord | input | 32 | Configuration word (period, delay, mode) |
| txStart | output | 1 | One-cycle strobe that starts a transmission |
| fsyncOut | output | 1 | Periodic one-cycle frame-sync pulse |

## Verification
The interesting overlap is the tick on which a transfer completes while a start condition is already present: a waiting word in mode 0, or a held level in modes 2 and 3. The bench raises `xferDone` while that condition is still held. It then expects the next `txStart` exactly one cycle later, or exactly D cycles after that when a delay is set. The opposite overlap is checked too: a start condition that arrives during a countdown or a busy transfer, and has already passed by the completion tick, must produce no start. Every expected strobe is queued with its exact cycle number, so any strobe at another cycle is an error.

// File: rtl/ser_tx_start_pkg.sv
`timescale 1ns/1ps
package ser_tx_start_pkg;

  // Field positions inside the configuration word.
  localparam int PERIOD_LSB = 24;
  localparam int DELAY_LSB  = 16;
  localparam int MODE_LSB   = 8;
  localparam int MODE_W     = 4;

  typedef enum logic [MODE_W-1:0] {
    SM_CONT   = 4'd0,
    SM_RX     = 4'd1,
    SM_LOW    = 4'd2,
    SM_HIGH   = 4'd3,
    SM_FALL   = 4'd4,
    SM_RISE   = 4'd5,
    SM_CHANGE = 4'd6,
    SM_EDGE   = 4'd7
  } startMode_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_BUSY
  } txState_t;

  // Strobes sent from the control FSM to the datapath.
  typedef struct packed {
    logic loadDelay;
    logic stepDelay;
    logic fire;
  } ctlStrobe_t;

endpackage

// File: rtl/ser_tx_start_dp.sv
`timescale 1ns/1ps
module ser_tx_start_dp
  import ser_tx_start_pkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int DELAY_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        txEnable,
  input  logic        wordReady,
  input  logic        rxStart,
  input  logic        fsyncIn,
  input  logic        cfgWrite,
  input  logic [31:0] cfgWord,
  input  ctlStrobe_t  strobe,
  output logic        trigger,
  output logic        delayZero,
  output logic        delayLast,
  output logic        txStart,
  output logic        fsyncOut
);

  localparam int FS_W = PERIOD_W + 1;

  // Configuration register.
  logic [PERIOD_W-1:0] periodReg;
  logic [DELAY_W-1:0]  delayReg;
  logic [MODE_W-1:0]   modeReg;
  logic                unusedCfgBits;

  assign unusedCfgBits = ^{cfgWord[15:12], cfgWord[7:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
      delayReg  <= '0;
      modeReg   <= '0;
    end else if (cfgWrite) begin
      periodReg <= cfgWord[PERIOD_LSB +: PERIOD_W];
      delayReg  <= cfgWord[DELAY_LSB +: DELAY_W];
      modeReg   <= cfgWord[MODE_LSB +: MODE_W];
    end
  end

  // Frame-sync input synchronizer, advanced on bit ticks.
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncCur;
  logic                   syncPrev;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        syncChain <= '0;
        else if (bitTick) syncChain <= fsyncIn;
      end
    end else begin : gSyncMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        syncChain <= '0;
        else if (bitTick) syncChain <= {syncChain[SYNC_STAGES-2:0], fsyncIn};
      end
    end
  endgenerate

  assign syncCur = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        syncPrev <= 1'b0;
    else if (bitTick) syncPrev <= syncCur;
  end

  // Start condition decode.
  always_comb begin
    case (modeReg)
      SM_CONT:   trigger = wordReady;
      SM_RX:     trigger = rxStart;
      SM_LOW:    trigger = !syncCur;
      SM_HIGH:   trigger = syncCur;
      SM_FALL:   trigger = syncPrev && !syncCur;
      SM_RISE:   trigger = !syncPrev && syncCur;
      SM_CHANGE: trigger = syncPrev ^ syncCur;
      SM_EDGE:   trigger = syncPrev ^ syncCur;
      default:   trigger = 1'b0;
    endcase
  end

  // Start delay counter.
  logic [DELAY_W-1:0] delayCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 delayCnt <= '0;
    else if (strobe.loadDelay) delayCnt <= delayReg;
    else if (strobe.stepDelay) delayCnt <= delayCnt - 1'b1;
  end

  assign delayZero = (delayReg == '0);
  assign delayLast = (delayCnt == DELAY_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txStart <= 1'b0;
    else       txStart <= strobe.fire;
  end

  // Periodic frame-sync generator: wraps after 2*(P+1) ticks.
  logic [FS_W-1:0] fsCnt;
  logic [FS_W-1:0] fsLast;

  assign fsLast = {periodReg, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsCnt    <= '0;
      fsyncOut <= 1'b0;
    end else begin
      fsyncOut <= 1'b0;
      if (cfgWrite || !txEnable) begin
        fsCnt <= '0;
      end else if (bitTick && (periodReg != '0)) begin
        if (fsCnt == fsLast) begin
          fsCnt    <= '0;
          fsyncOut <= 1'b1;
        end else begin
          fsCnt <= fsCnt + 1'b1;
        end
      end
    end
  end

  // R6: reserved encodings never present a start condition.
  a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    modeReg[MODE_W-1] |-> !trigger);

  // R9: a disabled transmitter gets no start strobe.
  a_r9_disabled_no_start: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !txStart);

  // R10: zero period keeps the frame sync quiet.
  a_r10_zero_period_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (periodReg == '0) |=> !fsyncOut);

  // R11: the frame-sync pulse is one cycle wide.
  a_r11_fsync_single: assert property (@(posedge clk) disable iff (!rstN)
    fsyncOut |=> !fsyncOut);

endmodule

// File: rtl/ser_tx_start_ctl.sv
`timescale 1ns/1ps
module ser_tx_start_ctl
  import ser_tx_start_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       txEnable,
  input  logic       xferDone,
  input  logic       trigger,
  input  logic       delayZero,
  input  logic       delayLast,
  output ctlStrobe_t strobe
);

  txState_t state;
  txState_t nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (bitTick && txEnable && trigger) begin
          if (delayZero) begin
            strobe.fire = 1'b1;
            nextState   = ST_BUSY;
          end else begin
            strobe.loadDelay = 1'b1;
            nextState        = ST_DELAY;
          end
        end
      end
      ST_DELAY: begin
        if (!txEnable) begin
          nextState = ST_IDLE;
        end else if (bitTick) begin
          if (delayLast) begin
            strobe.fire = 1'b1;
            nextState   = ST_BUSY;
          end else begin
            strobe.stepDelay = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        if (bitTick && xferDone) begin
          if (txEnable && trigger) begin
            if (delayZero) begin
              strobe.fire = 1'b1;
            end else begin
              strobe.loadDelay = 1'b1;
              nextState        = ST_DELAY;
            end
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R8: no start while a transfer runs, except on its completion tick.
  a_r8_busy_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && !(bitTick && xferDone)) |-> !strobe.fire);

  // R7: a countdown ends only when the datapath counter reaches its last tick.
  a_r7_delay_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DELAY && strobe.fire) |-> delayLast);

endmodule

// File: rtl/ser_tx_start_ctrl.sv
`timescale 1ns/1ps
module ser_tx_start_ctrl
  import ser_tx_start_pkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int DELAY_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        txEnable,
  input  logic        wordReady,
  input  logic        xferDone,
  input  logic        rxStart,
  input  logic        fsyncIn,
  input  logic        cfgWrite,
  input  logic [31:0] cfgWord,
  output logic        txStart,
  output logic        fsyncOut
);

  ctlStrobe_t strobe;
  logic       trigger;
  logic       delayZero;
  logic       delayLast;

  ser_tx_start_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .txEnable  (txEnable),
    .xferDone  (xferDone),
    .trigger   (trigger),
    .delayZero (delayZero),
    .delayLast (delayLast),
    .strobe    (strobe)
  );

  ser_tx_start_dp #(
    .PERIOD_W    (PERIOD_W),
    .DELAY_W     (DELAY_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .txEnable  (txEnable),
    .wordReady (wordReady),
    .rxStart   (rxStart),
    .fsyncIn   (fsyncIn),
    .cfgWrite  (cfgWrite),
    .cfgWord   (cfgWord),
    .strobe    (strobe),
    .trigger   (trigger),
    .delayZero (delayZero),
    .delayLast (delayLast),
    .txStart   (txStart),
    .fsyncOut  (fsyncOut)
  );

endmodule

// File: tb/ser_tx_start_ctrl_test.sv
`timescale 1ns/1ps
module ser_tx_start_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b1;
  logic        txEnable = 1'b0;
  logic        wordReady = 1'b0;
  logic        xferDone = 1'b0;
  logic        rxStart = 1'b0;
  logic        fsyncIn = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        txStart;
  logic        fsyncOut;

  ser_tx_start_ctrl uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .wordReady(wordReady), .xferDone(xferDone), .rxStart(rxStart),
    .fsyncIn(fsyncIn), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .txStart(txStart), .fsyncOut(fsyncOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    cyc = 0;
  int    nChecks = 0;
  int    nFail = 0;
  int    startCount = 0;
  int    fsCount = 0;
  bit    monOn = 1'b0;
  bit    finished = 1'b0;
  string curReq = "R1";

  int    startQ[$];
  string startTagQ[$];
  int    fsQ[$];
  string fsTagQ[$];

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expStart(int c, string req);
    startQ.push_back(c);
    startTagQ.push_back(req);
  endtask

  task automatic expFs(int c, string req);
    fsQ.push_back(c);
    fsTagQ.push_back(req);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseDone();
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  // R12: period in 31:24, delay in 23:16, mode in 11:8.
  task automatic writeCfg(int per, int dly, int mode);
    cfgWord  = {per[7:0], dly[7:0], 4'h0, mode[3:0], 8'h00};
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  // Scoreboard monitor for txStart.
  always @(negedge clk) begin
    if (monOn) begin
      while (startQ.size() > 0 && startQ[0] < cyc) begin
        check(1'b0, startTagQ[0], "missed txStart at cycle", cyc, startQ[0]);
        void'(startQ.pop_front());
        void'(startTagQ.pop_front());
      end
      if (txStart) begin
        startCount++;
        if (startQ.size() == 0) begin
          check(1'b0, curReq, "unexpected txStart at cycle", cyc, -1);
        end else begin
          check(startQ[0] == cyc, startTagQ[0], "txStart cycle", cyc, startQ[0]);
          void'(startQ.pop_front());
          void'(startTagQ.pop_front());
        end
      end
    end
  end

  // Scoreboard monitor for fsyncOut.
  always @(negedge clk) begin
    if (monOn) begin
      while (fsQ.size() > 0 && fsQ[0] < cyc) begin
        check(1'b0, fsTagQ[0], "missed fsyncOut at cycle", cyc, fsQ[0]);
        void'(fsQ.pop_front());
        void'(fsTagQ.pop_front());
      end
      if (fsyncOut) begin
        fsCount++;
        if (fsQ.size() == 0) begin
          check(1'b0, curReq, "unexpected fsyncOut at cycle", cyc, -1);
        end else begin
          check(fsQ[0] == cyc, fsTagQ[0], "fsyncOut cycle", cyc, fsQ[0]);
          void'(fsQ.pop_front());
          void'(fsTagQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int sc;
    int sf;
    int n;
    int q;
    int r;

    // R1: reset state.
    idle(3);
    check(txStart == 1'b0, "R1", "txStart in reset", txStart, 0);
    check(fsyncOut == 1'b0, "R1", "fsyncOut in reset", fsyncOut, 0);
    rstN = 1'b1;
    idle(2);
    monOn = 1'b1;

    // R1, R2: default mode 0 starts on a waiting word, no delay.
    curReq = "R2";
    txEnable  = 1'b1;
    wordReady = 1'b1;
    expStart(cyc + 1, "R1");
    idle(1);
    wordReady = 1'b0;
    idle(3);
    curReq = "R8";
    wordReady = 1'b1;          // busy: ignored
    idle(3);
    expStart(cyc + 1, "R2");   // completion tick with word waiting
    pulseDone();
    wordReady = 1'b0;
    idle(3);
    curReq = "R2";
    pulseDone();               // no word: back to idle
    idle(3);

    // R3: receiver start mode.
    writeCfg(0, 0, 1);
    curReq = "R3";
    sc = startCount;
    wordReady = 1'b1;
    idle(4);
    check(startCount == sc, "R3", "starts from a waiting word in mode 1", startCount - sc, 0);
    wordReady = 1'b0;
    rxStart = 1'b1;
    expStart(cyc + 1, "R3 R12");
    idle(1);
    rxStart = 1'b0;
    idle(2);
    curReq = "R8";
    rxStart = 1'b1;            // busy: ignored
    idle(1);
    rxStart = 1'b0;
    idle(2);
    pulseDone();
    idle(2);

    // R7: delay with receiver start; second event during countdown ignored.
    writeCfg(0, 5, 1);
    curReq = "R7";
    rxStart = 1'b1;
    expStart(cyc + 6, "R7");
    idle(1);
    rxStart = 1'b0;
    idle(1);
    rxStart = 1'b1;            // R8: in countdown
    idle(1);
    rxStart = 1'b0;
    idle(6);
    pulseDone();
    idle(2);

    // R7 with mode 0, including the completion-tick restart.
    writeCfg(0, 3, 0);
    wordReady = 1'b1;
    expStart(cyc + 4, "R7");
    idle(6);
    expStart(cyc + 4, "R7");
    pulseDone();
    idle(5);
    wordReady = 1'b0;
    pulseDone();
    idle(2);

    // R4: low level, re-armed at completion.
    fsyncIn = 1'b1;
    idle(4);
    writeCfg(0, 0, 2);
    curReq = "R4";
    fsyncIn = 1'b0;
    expStart(cyc + 3, "R4");
    idle(6);
    expStart(cyc + 1, "R4");
    pulseDone();
    idle(3);
    fsyncIn = 1'b1;
    idle(4);
    pulseDone();
    idle(3);

    // R4: high level.
    writeCfg(0, 0, 8);
    fsyncIn = 1'b0;
    idle(4);
    writeCfg(0, 0, 3);
    fsyncIn = 1'b1;
    expStart(cyc + 3, "R4");
    idle(6);
    fsyncIn = 1'b0;
    idle(4);
    pulseDone();
    idle(3);

    // R5: falling edge.
    writeCfg(0, 0, 4);
    curReq = "R5";
    fsyncIn = 1'b1;
    idle(5);
    fsyncIn = 1'b0;
    expStart(cyc + 3, "R5");
    idle(6);
    pulseDone();
    idle(5);

    // R5: rising edge.
    writeCfg(0, 0, 5);
    fsyncIn = 1'b1;
    expStart(cyc + 3, "R5");
    idle(6);
    pulseDone();
    idle(2);
    fsyncIn = 1'b0;
    idle(5);

    // R5: mode 6, any change.
    writeCfg(0, 0, 6);
    fsyncIn = 1'b1;
    expStart(cyc + 3, "R5");
    idle(6);
    pulseDone();
    idle(2);

    // R5: mode 7, both directions; R8: edge during busy ignored.
    writeCfg(0, 0, 7);
    fsyncIn = 1'b0;
    expStart(cyc + 3, "R5");
    idle(6);
    pulseDone();
    idle(2);
    fsyncIn = 1'b1;
    expStart(cyc + 3, "R5");
    idle(6);
    curReq = "R8";
    fsyncIn = 1'b0;
    idle(5);
    pulseDone();
    idle(4);

    // R6: reserved modes.
    curReq = "R6";
    writeCfg(0, 0, 9);
    sc = startCount;
    wordReady = 1'b1;
    rxStart = 1'b1;
    idle(1);
    rxStart = 1'b0;
    fsyncIn = 1'b1;
    idle(4);
    fsyncIn = 1'b0;
    idle(6);
    check(startCount == sc, "R6", "starts in mode 9", startCount - sc, 0);
    writeCfg(0, 0, 15);
    sc = startCount;
    rxStart = 1'b1;
    idle(1);
    rxStart = 1'b0;
    fsyncIn = 1'b1;
    idle(4);
    fsyncIn = 1'b0;
    idle(6);
    check(startCount == sc, "R6", "starts in mode 15", startCount - sc, 0);
    wordReady = 1'b0;

    // R9: disabled transmitter, and a countdown cancelled by disable.
    curReq = "R9";
    writeCfg(0, 0, 0);
    txEnable  = 1'b0;
    wordReady = 1'b1;
    sc = startCount;
    idle(5);
    check(startCount == sc, "R9", "starts while disabled", startCount - sc, 0);
    wordReady = 1'b0;
    idle(1);
    txEnable = 1'b1;
    writeCfg(0, 4, 1);
    sc = startCount;
    rxStart = 1'b1;
    idle(1);
    rxStart = 1'b0;
    idle(1);
    txEnable = 1'b0;
    idle(8);
    check(startCount == sc, "R9", "starts after cancelled countdown", startCount - sc, 0);
    txEnable = 1'b1;
    idle(6);
    check(startCount == sc, "R9", "starts after re-enable", startCount - sc, 0);

    // R10: zero period gives no frame sync.
    curReq = "R10";
    writeCfg(0, 0, 8);
    sf = fsCount;
    idle(30);
    check(fsCount == sf, "R10", "fsync pulses with period 0", fsCount - sf, 0);

    // R11: period 2 -> every 6 ticks.
    curReq = "R11";
    n = cyc;
    expFs(n + 7, "R11");
    expFs(n + 13, "R11");
    expFs(n + 19, "R11");
    writeCfg(2, 0, 8);
    idle(19);
    txEnable = 1'b0;
    idle(10);
    txEnable = 1'b1;
    q = cyc;
    expFs(q + 6, "R11");
    expFs(q + 12, "R11");
    idle(14);
    r = cyc;
    expFs(r + 5, "R11");
    expFs(r + 9, "R11");
    writeCfg(1, 0, 8);
    idle(9);
    curReq = "R10";
    writeCfg(0, 0, 8);
    sf = fsCount;
    idle(20);
    check(fsCount == sf, "R10", "fsync pulses after period cleared", fsCount - sf, 0);

    idle(2);
    check(startQ.size() == 0, "R2", "pending expected starts", startQ.size(), 0);
    check(fsQ.size() == 0, "R11", "pending expected fsync pulses", fsQ.size(), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule